// File: doc/BRIEF.md
# Budget-Driven Network Capacity Controller

This block picks how many channel increments of a runtime-configurable neural network are switched on for each inference. The network has four capacity levels. Each level turns on a larger uniform share of the channels in every layer except the output layer. The controller holds two budgets, one for energy and one for latency, and software may rewrite either of them at any time. After each inference the accelerator reports what that inference cost and pulses a done strobe. The controller compares both measurements with the budgets. If either one is over its budget, the capacity drops by one level.

The aim is to run the largest capacity that fits inside both budgets. The controller keeps no table that maps constraints to capacities. When a budget is raised it jumps back to the full network at the next inference boundary, then steps down again, one inference at a time, until the measurements fit. The accelerator reads the level output at the inference boundary. A one-cycle update strobe tells it that the new level is in place.

Top module: `cap_budget_ctrl`

## Requirements
- R1: After reset the level output is 3 (full network), the update strobe is low, and both budgets hold the all-ones value, so no measurement can exceed them.
- R2: The level output changes only in the clock cycle after an inference-done pulse. Budget writes alone never move it.
- R3: On an inference-done pulse, if the energy measurement is strictly greater than the energy budget, or the delay measurement is strictly greater than the delay budget, the level drops by exactly one.
- R4: The level never goes below 0. An over-budget inference at level 0 leaves it at 0.
- R5: A measurement equal to its budget is within budget. An inference with both measurements at or below their budgets leaves the level unchanged.
- R6: A budget write whose value is strictly greater than the value it replaces marks a raise. The next inference-done pulse then sets the level to 3, whatever the measurements are, and clears the mark. Later inferences step down normally.
- R7: A raising budget write in the same cycle as an inference-done pulse takes priority over a decrease. The level becomes 3.
- R8: A budget write with a value equal to or below the current budget is not a raise. The new value is the one compared on later inferences.
- R9: The update strobe is high for exactly one cycle, starting at the clock edge after each inference-done pulse. By then the level output already holds the new value.
- R10: Measurements and budgets are 32-bit unsigned values compared without sign. A measurement of 0x8000_0000 exceeds a budget of 150.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| energy_wr_i | input | 1 | Write strobe for the energy budget |
| energy_wdata_i | input | 32 | New energy budget value |
| delay_wr_i | input | 1 | Write strobe for the delay budget |
| delay_wdata_i | input | 32 | New delay budget value |
| infer_done_i | input | 1 | One-cycle pulse at the end of an inference |
| energy_meas_i | input | 32 | Energy measured for the finished inference |
| delay_meas_i | input | 32 | Delay measured for the finished inference |
| level_o | output | 2 | Active capacity increment (0 smallest, 3 full network) |
| level_upd_o | output | 1 | One-cycle strobe: the level was re-evaluated |

## Verification
The bench builds the block with its default parameters: 32-bit measurements and four levels. At this size the whole staircase from the full network down to the floor at 0 can be walked in a few inferences. Small budget values make the equal-to-budget boundary and the strictly-greater raise test easy to hit exactly. The 32-bit width lets a measurement with its top bit set show that the comparison is unsigned.

// File: rtl/cap_ctrl_pkg.sv
package cap_ctrl_pkg;
  // What a finished inference does to the capacity level
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_DOWN = 2'd1,
    EV_FULL = 2'd2
  } lvl_evt_e;
endpackage

// File: rtl/budget_reg.sv
module budget_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         raise_o
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en    = wr_i;
    q_d     = wdata_i;
    raise_o = wr_i && (wdata_i > q_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (q_en) q_o <= q_d;
  end

  // R8: a write lands in the register on the next edge
  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o == $past(wdata_i)));
  a_r2_budget_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/overrun_cmp.sv
module overrun_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] meas_i,
  input  logic [W-1:0] lim_i,
  output logic         over_o
);
  always_comb over_o = meas_i > lim_i;
endmodule

// File: rtl/level_ctrl.sv
module level_ctrl
  import cap_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LW = $clog2(NUM_LEVELS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          raise_i,
  input  logic          over_i,
  output logic [LW-1:0] lvl_o,
  output logic          upd_o
);
  localparam logic [LW-1:0] LVL_MAX = LW'(NUM_LEVELS - 1);

  lvl_evt_e      evt;
  logic [LW-1:0] lvl_d;
  logic          lvl_en;
  logic          pend_q, pend_d;

  always_comb begin
    if (pend_q || raise_i) evt = EV_FULL;
    else if (over_i)       evt = EV_DOWN;
    else                   evt = EV_HOLD;

    lvl_en = done_i;
    unique case (evt)
      EV_FULL: lvl_d = LVL_MAX;
      EV_DOWN: lvl_d = (lvl_o == '0) ? '0 : lvl_o - LW'(1);
      default: lvl_d = lvl_o;
    endcase

    if (done_i)       pend_d = 1'b0;
    else if (raise_i) pend_d = 1'b1;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= LVL_MAX;
      pend_q <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      if (lvl_en) lvl_o <= lvl_d;
      pend_q <= pend_d;
      upd_o  <= done_i;
    end
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(lvl_o));
  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !raise_i && !pend_q && over_i && lvl_o != '0) |=> (lvl_o == $past(lvl_o) - LW'(1)));
  a_r4_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !raise_i && !pend_q && lvl_o == '0) |=> (lvl_o == '0));
  a_r5_within: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !raise_i && !pend_q && !over_i) |=> $stable(lvl_o));
  a_r6_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && !done_i) |=> pend_q);
  a_r7_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && raise_i) |=> (lvl_o == LVL_MAX && !pend_q));
  a_r9_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> upd_o);
endmodule

// File: rtl/cap_budget_ctrl.sv
module cap_budget_ctrl #(
  parameter int unsigned MEAS_W     = 32,
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LW = $clog2(NUM_LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              energy_wr_i,
  input  logic [MEAS_W-1:0] energy_wdata_i,
  input  logic              delay_wr_i,
  input  logic [MEAS_W-1:0] delay_wdata_i,
  input  logic              infer_done_i,
  input  logic [MEAS_W-1:0] energy_meas_i,
  input  logic [MEAS_W-1:0] delay_meas_i,
  output logic [LW-1:0]     level_o,
  output logic              level_upd_o
);
  localparam int unsigned NCH = 2; // 0 energy, 1 delay

  logic [NCH-1:0]             ch_wr, ch_raise, ch_over;
  logic [NCH-1:0][MEAS_W-1:0] ch_wdata, ch_meas, ch_lim;

  always_comb begin
    ch_wr    = {delay_wr_i, energy_wr_i};
    ch_wdata = {delay_wdata_i, energy_wdata_i};
    ch_meas  = {delay_meas_i, energy_meas_i};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    budget_reg #(.W(MEAS_W)) u_budget (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr[c]),
      .wdata_i (ch_wdata[c]),
      .q_o     (ch_lim[c]),
      .raise_o (ch_raise[c])
    );
    overrun_cmp #(.W(MEAS_W)) u_cmp (
      .meas_i (ch_meas[c]),
      .lim_i  (ch_lim[c]),
      .over_o (ch_over[c])
    );
  end

  level_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_lvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (infer_done_i),
    .raise_i (|ch_raise),
    .over_i  (|ch_over),
    .lvl_o   (level_o),
    .upd_o   (level_upd_o)
  );
endmodule

// File: tb/cap_budget_ctrl_test.sv
`timescale 1ns/1ps
module cap_budget_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e_wr = 1'b0, d_wr = 1'b0, done = 1'b0;
  logic [31:0] e_wd = '0, d_wd = '0, e_m = '0, d_m = '0;
  logic [1:0]  lvl;
  logic        upd;

  int n_chk = 0, n_bad = 0, n_upd = 0, n_done = 0;
  logic [1:0]  exp_q[$];
  logic [1:0]  m_lvl;
  logic [31:0] m_eb, m_db;
  logic        m_pend;

  always #2.5 clk = ~clk;

  cap_budget_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .energy_wr_i(e_wr), .energy_wdata_i(e_wd),
    .delay_wr_i(d_wr), .delay_wdata_i(d_wd),
    .infer_done_i(done), .energy_meas_i(e_m), .delay_meas_i(d_m),
    .level_o(lvl), .level_upd_o(upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each update strobe (R9)
  always @(negedge clk) begin
    if (rst_n && upd) begin
      n_upd++;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected strobe", 1, 0);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(lvl == e, "R9 scoreboard level", lvl, e);
      end
    end
  end

  function automatic void model_done(input logic [31:0] e, input logic [31:0] d, input logic raise_now);
    if (m_pend || raise_now) m_lvl = 2'd3;
    else if (e > m_eb || d > m_db) m_lvl = (m_lvl == 0) ? 2'd0 : m_lvl - 2'd1;
    m_pend = 1'b0;
  endfunction

  task automatic infer(input logic [31:0] e, input logic [31:0] d, input string req);
    @(negedge clk);
    done = 1'b1; e_m = e; d_m = d;
    model_done(e, d, 1'b0);
    exp_q.push_back(m_lvl);
    n_done++;
    @(negedge clk);
    done = 1'b0;
    chk(lvl == m_lvl, req, lvl, m_lvl);
    chk(upd == 1'b1, "R9 strobe high", upd, 1);
  endtask

  task automatic wr_budget(input bit is_delay, input logic [31:0] v);
    @(negedge clk);
    if (is_delay) begin
      d_wr = 1'b1; d_wd = v;
      if (v > m_db) m_pend = 1'b1;
      m_db = v;
    end else begin
      e_wr = 1'b1; e_wd = v;
      if (v > m_eb) m_pend = 1'b1;
      m_eb = v;
    end
    @(negedge clk);
    e_wr = 1'b0; d_wr = 1'b0;
    chk(upd == 1'b0, "R9 strobe low after one cycle", upd, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_lvl = 2'd3; m_eb = '1; m_db = '1; m_pend = 1'b0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(lvl == 2'd3, "R1 reset level", lvl, 3);
    chk(upd == 1'b0, "R1 reset strobe", upd, 0);
    infer(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 all-ones budgets never exceeded");

    wr_budget(1'b0, 32'd100);                       // lower: no raise (R8)
    infer(32'd100, 32'd0, "R5 equal to budget holds");
    infer(32'd101, 32'd0, "R3 R8 energy over new budget steps down");
    wr_budget(1'b1, 32'd50);
    infer(32'd0, 32'd51, "R3 delay over steps down");
    infer(32'd200, 32'd200, "R3 both over steps to 0");
    infer(32'd200, 32'd200, "R4 saturates at 0");
    wr_budget(1'b0, 32'd100);                       // equal: no raise (R8)
    infer(32'd0, 32'd0, "R8 equal write is no raise");

    wr_budget(1'b0, 32'd150);                       // raise
    repeat (3) @(negedge clk);
    chk(lvl == 2'd0, "R2 level unmoved by budget write", lvl, 0);
    infer(32'd500, 32'd500, "R6 raise jumps to full");
    infer(32'd500, 32'd0, "R6 mark cleared then steps down");

    // R7: raise and done together, measurements over budget
    @(negedge clk);
    d_wr = 1'b1; d_wd = 32'd60; m_db = 32'd60;
    done = 1'b1; e_m = 32'd999; d_m = 32'd999;
    model_done(32'd999, 32'd999, 1'b1);
    exp_q.push_back(m_lvl); n_done++;
    @(negedge clk);
    d_wr = 1'b0; done = 1'b0;
    chk(lvl == 2'd3, "R7 raise beats decrease", lvl, 3);

    infer(32'h8000_0000, 32'd0, "R10 unsigned compare");
    chk(lvl == 2'd2, "R10 level after top-bit measurement", lvl, 2);
    infer(32'd150, 32'd60, "R5 both equal holds");

    repeat (3) @(negedge clk);
    chk(n_upd == n_done, "R9 strobe count", n_upd, n_done);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule